// File: doc/BRIEF.md
# Memory Port Write-Read Test Client

This block sits on the user side of one port of a multi-port DRAM controller. It runs a write-then-read integrity loop that never ends. After reset it stays idle until the controller reports that calibration is done. Each pass of the loop has four steps:

1. It queues a burst of 64-bit words into the port's write-data FIFO.
2. It issues a write command for that burst.
3. It issues a read command for the same byte address.
4. It drains the read-data FIFO and compares every returned word with the word it wrote.

The data pattern depends on the iteration number, so a write that never reached memory shows up as a mismatch on the following read. A saturating error counter and a sticky fail flag report the result.

All three port FIFOs (command, write data, read data) run on the same user clock as this block. The port uses these conventions:

- The write data for a burst is queued before the command that consumes it.
- The burst-length field holds the word count minus one.
- The read FIFO shows the word at its head whenever its empty flag is low. Asserting read-enable pops that word.

The controller is modelled behaviourally in the bench.

The sequencer is a five-state machine:

| State | Role | Exit |
|---|---|---|
| `ST_WAIT_CAL` | Idle after reset | Goes to `ST_FILL` on calibration done |
| `ST_FILL` | Pushes one pattern word per cycle while the write FIFO is not full | Goes to `ST_WR_CMD` after the last word |
| `ST_WR_CMD` | Issues the write command when the command FIFO has room | Goes to `ST_RD_CMD` |
| `ST_RD_CMD` | Issues the read command when the command FIFO has room | Goes to `ST_DRAIN` |
| `ST_DRAIN` | Pops and checks one word in each cycle the read FIFO is not empty | Goes back to `ST_FILL` after the last word and advances the iteration |

Top module: `mem_port_checker`

## Requirements
- R1: While calibration done has not been seen since reset, cmd_en, wr_en and rd_en all stay low.
- R2: Every command has these fields:
  - cmd_bl = BURST_LEN-1.
  - cmd_byte_addr = TEST_ADDR.
  - cmd_instr = 3'b000 for a write and 3'b001 for a read.
- R3: Exactly BURST_LEN words are pushed into the write FIFO before each write command, with no push between that write command and the read command that follows it.
- R4: cmd_en is high only in cycles where cmd_full is low, and each high cycle is one accepted command.
- R5: wr_en is never high while wr_full is high, and wr_mask is all zeros in every cycle where wr_en is high.
- R6: rd_en is high only while rd_empty is low, and each read command is followed by exactly BURST_LEN pops.
- R7: Word k of iteration n, written and expected alike, is PAT_BASE + n*2^ITER_SHIFT + k, taken modulo 2^64. Iteration 0 follows reset.
- R8: Each popped word that differs from its expected value raises err_count by one in the next cycle. err_count saturates at 2^ERR_W-1 and never decreases except at reset.
- R9: test_fail rises in the cycle after the first mismatch and stays high until reset.
- R10: While rst is high, all strobes, err_count and test_fail are zero, and the iteration count restarts at 0.
- R11: A read that returns the previous iteration's data, because the write was lost, counts a mismatch for every word of the burst.
- R12: Commands strictly alternate write then read, starting with a write, as the state sequence ST_FILL, ST_WR_CMD, ST_RD_CMD, ST_DRAIN, ST_FILL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock shared with the port FIFOs |
| rst | input | 1 | Synchronous active-high reset |
| calib_done | input | 1 | Controller calibration complete |
| cmd_full | input | 1 | Command FIFO cannot accept a command |
| cmd_en | output | 1 | Command push strobe |
| cmd_instr | output | 3 | 3'b000 write, 3'b001 read |
| cmd_bl | output | 6 | Burst length minus one |
| cmd_byte_addr | output | 30 | Command byte address |
| wr_full | input | 1 | Write-data FIFO full |
| wr_en | output | 1 | Write-data push strobe |
| wr_mask | output | 8 | Byte mask, all zeros |
| wr_data | output | 64 | Word being pushed |
| rd_empty | input | 1 | Read-data FIFO empty |
| rd_en | output | 1 | Read-data pop strobe |
| rd_data | input | 64 | Word at the head of the read FIFO |
| err_count | output | ERR_W | Saturating mismatch count |
| test_fail | output | 1 | Sticky mismatch flag |

## Verification
The strobes and command fields are combinational from the state and the FIFO flags, so they are due in the same cycle as the flag that enables them. The bench samples them at the falling edge, which is before the rising edge at which the port model acts on them.

err_count and test_fail are registered, so they are due one cycle after the pop. A bench-side error model is updated at each pop, and the outputs are compared with it at the next falling edge.

Stalls on all three FIFOs come from a shift-register sequence. Corrupted words and a dropped write are injected between iterations, and each is checked once its burst has fully drained.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
    localparam int DATA_W  = 64;
    localparam int MASK_W  = 8;
    localparam int ADDR_W  = 30;
    localparam int BL_W    = 6;
    localparam int INSTR_W = 3;

    localparam logic [INSTR_W-1:0] INSTR_WRITE = 3'b000;
    localparam logic [INSTR_W-1:0] INSTR_READ  = 3'b001;

    typedef enum logic [2:0] {
        ST_WAIT_CAL,
        ST_FILL,
        ST_WR_CMD,
        ST_RD_CMD,
        ST_DRAIN
    } mpc_state_t;
endpackage

// File: rtl/mpc_pattern.sv
module mpc_pattern #(
    parameter int                DATA_W     = 64,
    parameter int                ITER_W     = 32,
    parameter int                IDX_W      = 3,
    parameter int                ITER_SHIFT = 16,
    parameter logic [DATA_W-1:0] PAT_BASE   = '0
) (
    input  logic [ITER_W-1:0] iter,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    // Iteration number lands above the word index so stale bursts differ.
    assign word = PAT_BASE + (DATA_W'(iter) << ITER_SHIFT) + DATA_W'(idx);
endmodule

// File: rtl/mpc_err_track.sv
module mpc_err_track #(
    parameter int DATA_W = 64,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_valid,
    input  logic [DATA_W-1:0] got,
    input  logic [DATA_W-1:0] want,
    output logic [ERR_W-1:0]  err_count,
    output logic              test_fail
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic mismatch;
    assign mismatch = chk_valid && (got != want);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_count <= '0;
            test_fail <= 1'b0;
        end else if (mismatch) begin
            test_fail <= 1'b1;
            if (err_count != ERR_MAX) begin
                err_count <= err_count + 1'b1;
            end
        end
    end

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        test_fail |=> test_fail);

    // R8
    err_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> err_count >= $past(err_count));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> $stable(err_count));
endmodule

// File: rtl/mem_port_checker.sv
module mem_port_checker
    import mpc_pkg::*;
#(
    parameter int                BURST_LEN  = 8,
    parameter logic [ADDR_W-1:0] TEST_ADDR  = 30'h0000_0100,
    parameter logic [DATA_W-1:0] PAT_BASE   = 64'hA5A5_0000_0000_1000,
    parameter int                ITER_SHIFT = 16,
    parameter int                ITER_W     = 32,
    parameter int                ERR_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               calib_done,
    input  logic               cmd_full,
    output logic               cmd_en,
    output logic [INSTR_W-1:0] cmd_instr,
    output logic [BL_W-1:0]    cmd_bl,
    output logic [ADDR_W-1:0]  cmd_byte_addr,
    input  logic               wr_full,
    output logic               wr_en,
    output logic [MASK_W-1:0]  wr_mask,
    output logic [DATA_W-1:0]  wr_data,
    input  logic               rd_empty,
    output logic               rd_en,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [ERR_W-1:0]   err_count,
    output logic               test_fail
);
    localparam int             IDX_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);
    localparam logic [BL_W-1:0]  BL_CODE  = BL_W'(BURST_LEN - 1);

    mpc_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [ITER_W-1:0] iter_q, iter_d;
    logic [DATA_W-1:0] pat_word;

    // Next-state and counters.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        iter_d  = iter_q;
        unique case (state_q)
            ST_WAIT_CAL: begin
                if (calib_done) begin
                    state_d = ST_FILL;
                    idx_d   = '0;
                end
            end
            ST_FILL: begin
                if (!wr_full) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_WR_CMD;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_WR_CMD: begin
                if (!cmd_full) state_d = ST_RD_CMD;
            end
            ST_RD_CMD: begin
                if (!cmd_full) begin
                    state_d = ST_DRAIN;
                    idx_d   = '0;
                end
            end
            ST_DRAIN: begin
                if (!rd_empty) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_FILL;
                        idx_d   = '0;
                        iter_d  = iter_q + 1'b1;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_WAIT_CAL;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_CAL;
            idx_q   <= '0;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            iter_q  <= iter_d;
        end
    end

    // Outputs.
    always_comb begin
        cmd_en        = 1'b0;
        cmd_instr     = INSTR_WRITE;
        cmd_bl        = BL_CODE;
        cmd_byte_addr = TEST_ADDR;
        wr_en         = 1'b0;
        wr_mask       = '0;
        wr_data       = pat_word;
        rd_en         = 1'b0;
        unique case (state_q)
            ST_WAIT_CAL: ;
            ST_FILL:     wr_en = !wr_full;
            ST_WR_CMD:   cmd_en = !cmd_full;
            ST_RD_CMD: begin
                cmd_en    = !cmd_full;
                cmd_instr = INSTR_READ;
            end
            ST_DRAIN:    rd_en = !rd_empty;
            default: ;
        endcase
    end

    // One generator serves both fill and drain: idx counts words in each.
    mpc_pattern #(
        .DATA_W    (DATA_W),
        .ITER_W    (ITER_W),
        .IDX_W     (IDX_W),
        .ITER_SHIFT(ITER_SHIFT),
        .PAT_BASE  (PAT_BASE)
    ) u_pattern (
        .iter(iter_q),
        .idx (idx_q),
        .word(pat_word)
    );

    mpc_err_track #(
        .DATA_W(DATA_W),
        .ERR_W (ERR_W)
    ) u_err (
        .clk      (clk),
        .rst      (rst),
        .chk_valid(rd_en),
        .got      (rd_data),
        .want     (pat_word),
        .err_count(err_count),
        .test_fail(test_fail)
    );

    // Checker state: calibration seen since reset.
    logic cal_seen;
    always_ff @(posedge clk) begin
        if (rst)             cal_seen <= 1'b0;
        else if (calib_done) cal_seen <= 1'b1;
    end

    // R1
    cal_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cal_seen |-> !(cmd_en || wr_en || rd_en));

    // R4
    cmd_room_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_full |-> !cmd_en);

    // R5
    wr_room_chk: assert property (@(posedge clk) disable iff (rst)
        wr_full |-> !wr_en);

    // R5
    mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_mask == '0));

    // R6
    rd_avail_chk: assert property (@(posedge clk) disable iff (rst)
        rd_empty |-> !rd_en);

    // R2
    instr_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_en |-> (cmd_instr == INSTR_WRITE || cmd_instr == INSTR_READ));

    // R12
    rd_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_en && cmd_instr == INSTR_WRITE) |=> !wr_en && !rd_en);
endmodule

// File: tb/mem_port_checker_bench.sv
module mem_port_checker_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          BURST      = 8;
    localparam int          ERRW       = 4;
    localparam int          EMAX       = 15;
    localparam logic [29:0] TADDR      = 30'h0000_0100;
    localparam logic [63:0] PBASE      = 64'hA5A5_0000_0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        calib_done = 1'b0;
    logic        cmd_full = 1'b0;
    logic        cmd_en;
    logic [2:0]  cmd_instr;
    logic [5:0]  cmd_bl;
    logic [29:0] cmd_byte_addr;
    logic        wr_full = 1'b0;
    logic        wr_en;
    logic [7:0]  wr_mask;
    logic [63:0] wr_data;
    logic        rd_empty;
    logic        rd_en;
    logic [63:0] rd_data;
    logic [ERRW-1:0] err_count;
    logic        test_fail;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_port_checker #(
        .BURST_LEN(BURST), .TEST_ADDR(TADDR), .PAT_BASE(PBASE),
        .ITER_SHIFT(16), .ITER_W(32), .ERR_W(ERRW)
    ) u_mem_port_checker (
        .clk(clk), .rst(rst), .calib_done(calib_done),
        .cmd_full(cmd_full), .cmd_en(cmd_en), .cmd_instr(cmd_instr),
        .cmd_bl(cmd_bl), .cmd_byte_addr(cmd_byte_addr),
        .wr_full(wr_full), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
        .rd_empty(rd_empty), .rd_en(rd_en), .rd_data(rd_data),
        .err_count(err_count), .test_fail(test_fail)
    );

    function automatic logic [63:0] pat(input int it, input int ix);
        return PBASE + (64'(it) << 16) + 64'(ix);
    endfunction

    // ---------------- behavioural port model ----------------
    logic [63:0] wq  [0:63];
    logic [63:0] mem [0:63];
    logic [63:0] rq  [0:63];
    logic [5:0]  wq_ptr = '0, rq_head = '0, rq_tail = '0, rd_ptr = '0;
    int          rq_cnt = 0, rd_left = 0, rd_delay = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        stall_en = 1'b0, drop_writes = 1'b0;
    int          corrupt_goal = 0, corrupt_done = 0;
    logic        do_push, do_pop;
    logic [63:0] pw;

    assign rd_empty = (rq_cnt == 0);
    assign rd_data  = rq[rq_head];

    always @(posedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_full  <= stall_en & lfsr[0] & lfsr[3];
        cmd_full <= stall_en & lfsr[1] & lfsr[5];
        if (rst) begin
            wq_ptr <= '0; rq_head <= '0; rq_tail <= '0; rq_cnt <= 0;
            rd_left <= 0; rd_delay <= 0;
            for (int i = 0; i < 64; i++) mem[i] <= '0;
        end else begin
            if (wr_en) begin
                wq[wq_ptr] <= wr_data;
                wq_ptr <= wq_ptr + 6'd1;
            end
            if (cmd_en && cmd_instr == 3'b000) begin
                if (!drop_writes)
                    for (int k = 0; k <= int'(cmd_bl); k++)
                        mem[cmd_byte_addr[8:3] + 6'(k)] <= wq[6'(k)];
                wq_ptr <= '0;
            end
            if (cmd_en && cmd_instr == 3'b001) begin
                rd_left  <= int'(cmd_bl) + 1;
                rd_ptr   <= cmd_byte_addr[8:3];
                rd_delay <= 5;
            end
            do_push = (rd_left > 0) && (rd_delay == 0) && !(stall_en && lfsr[2]);
            do_pop  = rd_en;
            if (rd_delay > 0) rd_delay <= rd_delay - 1;
            if (do_push) begin
                pw = mem[rd_ptr];
                if (corrupt_done < corrupt_goal) begin
                    pw = pw ^ 64'h1;
                    corrupt_done <= corrupt_done + 1;
                end
                rq[rq_tail] <= pw;
                rq_tail <= rq_tail + 6'd1;
                rd_ptr  <= rd_ptr + 6'd1;
                rd_left <= rd_left - 1;
            end
            if (do_pop) rq_head <= rq_head + 6'd1;
            rq_cnt <= rq_cnt + (do_push ? 1 : 0) - (do_pop ? 1 : 0);
        end
    end

    // ---------------- monitor (falling edge) ----------------
    int v_cal = 0, v_fmt = 0, v_order = 0, v_cfull = 0, v_wfull = 0, v_mask = 0;
    int v_rd = 0, v_pat = 0, v_err = 0, v_seq = 0;
    int m_iter = 0, m_idx = 0, r_iter = 0, r_idx = 0, pops = 0, n_push = 0, n_cmd = 0;
    int e_model = 0;
    bit f_model = 0, m_expect_wr = 1, got_first = 0;
    logic [63:0] first_word = '0;

    always @(negedge clk) begin
        if (rst) begin
            m_iter = 0; m_idx = 0; r_iter = 0; r_idx = 0; pops = 0;
            n_push = 0; n_cmd = 0; e_model = 0; f_model = 0;
            m_expect_wr = 1; got_first = 0;
        end else begin
            if (!calib_done && (cmd_en || wr_en || rd_en)) v_cal++;
            // R8 R9: registered results reflect pops up to last cycle
            if (int'(err_count) != e_model || test_fail != f_model) v_err++;
            if (wr_en) begin
                if (wr_mask != 8'h00) v_mask++;
                if (wr_full) v_wfull++;
                if (wr_data != pat(m_iter, m_idx)) v_pat++;
                if (!m_expect_wr) v_order++;
                if (!got_first) begin first_word = wr_data; got_first = 1; end
                m_idx++; n_push++;
            end
            if (cmd_en) begin
                if (cmd_full) v_cfull++;
                if (cmd_bl != 6'(BURST - 1) || cmd_byte_addr != TADDR) v_fmt++;
                if (m_expect_wr) begin
                    if (cmd_instr != 3'b000) v_seq++;
                    if (m_idx != BURST) v_order++;
                    m_idx = 0;
                end else begin
                    if (cmd_instr != 3'b001) v_seq++;
                    m_iter++;
                end
                m_expect_wr = !m_expect_wr;
                n_cmd++;
            end
            if (rd_en) begin
                if (rd_empty) v_rd++;
                if (rd_data != pat(r_iter, r_idx)) begin
                    e_model = (e_model < EMAX) ? e_model + 1 : EMAX;
                    f_model = 1;
                end
                pops++; r_idx++;
                if (r_idx == BURST) begin r_idx = 0; r_iter++; end
            end
        end
    end

    // ---------------- checks ----------------
    int total = 0, bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_iters(input int n);
        while (pops < n * BURST) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_idle(input string what);
        check(!cmd_en && !wr_en && !rd_en, {what, " strobes"},
              longint'({cmd_en, wr_en, rd_en}), 0);
        check(err_count == '0 && !test_fail, {what, " result"},
              longint'(err_count) + (test_fail ? 100 : 0), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R10 reset");
        rst = 1'b0;
        repeat (40) @(negedge clk);
        check(n_push == 0 && n_cmd == 0, "R1 idle before calibration", longint'(n_push + n_cmd), 0);
        calib_done = 1'b1;
        stall_en   = 1'b1;

        wait_iters(3);
        check(err_count == 0 && !test_fail, "R8 clean loops", longint'(err_count), 0);
        check(pops == 3 * BURST && rd_empty, "R6 pops per read", longint'(pops), longint'(3 * BURST));
        check(n_cmd == 6, "R12 command count", longint'(n_cmd), 6);

        corrupt_goal = corrupt_goal + 1;
        wait_iters(4);
        check(int'(err_count) == 1, "R8 single mismatch", longint'(err_count), 1);
        check(test_fail == 1'b1, "R9 fail raised", longint'(test_fail), 1);

        wait_iters(6);
        check(int'(err_count) == 1, "R8 count holds on clean loops", longint'(err_count), 1);
        check(test_fail == 1'b1, "R9 fail sticky", longint'(test_fail), 1);

        drop_writes = 1'b1;
        wait_iters(7);
        drop_writes = 1'b0;
        check(int'(err_count) == 1 + BURST, "R11 stale burst", longint'(err_count), longint'(1 + BURST));

        corrupt_goal = corrupt_goal + BURST;
        wait_iters(8);
        check(int'(err_count) == EMAX, "R8 saturation reached", longint'(err_count), longint'(EMAX));
        corrupt_goal = corrupt_goal + BURST;
        wait_iters(9);
        check(int'(err_count) == EMAX, "R8 saturation held", longint'(err_count), longint'(EMAX));

        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R10 mid-run reset");
        rst = 1'b0;
        wait_iters(2);
        check(first_word == PBASE, "R10 R7 iteration restarts", longint'(first_word[31:0]), longint'(PBASE[31:0]));
        check(err_count == 0 && !test_fail, "R10 clean after reset", longint'(err_count), 0);

        check(v_cal == 0, "R1 activity before calibration", longint'(v_cal), 0);
        check(v_fmt == 0, "R2 command fields", longint'(v_fmt), 0);
        check(v_order == 0, "R3 fill before write command", longint'(v_order), 0);
        check(v_cfull == 0, "R4 command while full", longint'(v_cfull), 0);
        check(v_wfull == 0, "R5 push while full", longint'(v_wfull), 0);
        check(v_mask == 0, "R5 mask zero", longint'(v_mask), 0);
        check(v_rd == 0, "R6 pop while empty", longint'(v_rd), 0);
        check(v_pat == 0, "R7 write pattern", longint'(v_pat), 0);
        check(v_err == 0, "R8 R9 error timing", longint'(v_err), 0);
        check(v_seq == 0, "R12 write/read alternation", longint'(v_seq), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule